// File: doc/BRIEF.md
# SD Command and Response Engine

This block sends one command on the single-wire command line of an SD or MMC card and collects the reply. Software writes a 32-bit argument and a control word. The control word holds a 6-bit command index, a start bit, a wait-for-response bit and a long-response bit. The block then builds a 48-bit frame with its 7-bit CRC and shifts it out. If a reply is requested, it listens for a 48-bit short reply or a 136-bit long reply. It copies the payload into four 32-bit response outputs.

Results appear as four sticky flags: command sent, response received, response timeout and response CRC mismatch. Writing a one to a flag clears it. The card clock comes from the system clock through a programmable divider. The divider may be changed between commands, so identification can run slowly and transfers can run fast. Commands whose reply carries an operating-conditions word have no valid CRC. For those, a per-command input suppresses the CRC flag.

Top module: `sd_cmd_engine`

## Requirements
- R1: The first byte on the line is a 0 start bit, a 1 transmission bit and the 6-bit index taken from control bits [5:0]. Control bits [7:6] are ignored. The 32-bit argument follows, most significant bit first.
- R2: After the argument the frame carries a CRC7 (polynomial x^7+x^3+1, register cleared, fed MSB first) over the first 40 bits, then an end bit of 1.
- R3: With divider value P, the effective value is E = P, or 1 when P = 0. The card clock period is E+1 system clocks, and its high phase lasts (E+1)/2 system clocks, rounded down.
- R4: The line is driven (cmd_oe=1) only while the 48 command bits are sent, and cmd_out changes only on a card clock falling edge. When the frame ends, the line is released and the command-sent flag (status bit 11) is set.
- R5: Control word layout: bit 8 = start, bit 9 = wait for response, bit 10 = long response. With bit 9 clear, the command-sent flag alone marks completion: no other flag is set and busy falls.
- R6: A short reply is sampled on card clock rising edges. When it has been received, resp0 holds its bits 39:8 and the response flag (status bit 9) is set.
- R7: A long reply is 136 bits. resp0..resp3 hold its bits 127:0, with resp0 the most significant word, and the response flag is set.
- R8: If 64 rising edges sample the line high after the command, the timeout flag (status bit 10) is set without the response flag. A start bit sampled on the 64th edge is still accepted.
- R9: If the received CRC7 does not match the one recomputed over bits 47:8 (short) or bits 127:8 (long), the CRC flag (status bit 12) is set together with the response flag.
- R10: crc_skip, latched when a command starts, suppresses the CRC flag for that command.
- R11: Writing status with a bit set to 1 clears that flag. When a set and a clear meet in the same cycle, the set wins.
- R12: A start request while busy is ignored, as is a control write with bit 8 clear.
- R13: After reset: busy=0, cmd_oe=0, cmd_out=1, all flags 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| presc | input | PRESC_W | Card clock divider value |
| cmd_arg | input | 32 | Command argument |
| ctl_we | input | 1 | Control word write strobe |
| ctl_word | input | 11 | Index [5:0], start [8], wait response [9], long [10] |
| crc_skip | input | 1 | Suppress CRC flag for this command |
| sts_we | input | 1 | Status write (clear) strobe |
| sts_wdata | input | 4 | Ones clear the matching flags, bits 12:9 |
| sts | output | 4 | Flags: 12 CRC, 11 sent, 10 timeout, 9 response |
| resp0 | output | 32 | Response word 0 (most significant of long) |
| resp1 | output | 32 | Response word 1 |
| resp2 | output | 32 | Response word 2 |
| resp3 | output | 32 | Response word 3 |
| busy | output | 1 | Command or response in progress |
| sd_clk | output | 1 | Card clock |
| cmd_out | output | 1 | Command line output value |
| cmd_oe | output | 1 | Command line output enable |
| cmd_in | input | 1 | Command line input value |

## Verification
A flag can be set by the engine in the same system clock cycle in which software writes ones to clear the status. That case decides whether a completion is lost. The bench issues a command without a response and tracks the card clock. It drives a single-cycle all-ones status write exactly on the edge where the sent flag rises, which is the falling card clock edge after the end bit. It then expects the sent flag set and the older response flag cleared. Random commands with random reply delays and corrupted CRCs give wide coverage of completion events.

// File: rtl/sd_cmd_engine.sv
module sd_cmd_engine #(
  parameter int PRESC_W  = 8,
  parameter int TOUT_CYC = 64,
  parameter int TOUT_W   = $clog2(TOUT_CYC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PRESC_W-1:0] presc,
  input  logic [31:0]        cmd_arg,
  input  logic               ctl_we,
  input  logic [10:0]        ctl_word,
  input  logic               crc_skip,
  input  logic               sts_we,
  input  logic [12:9]        sts_wdata,
  output logic [12:9]        sts,
  output logic [31:0]        resp0,
  output logic [31:0]        resp1,
  output logic [31:0]        resp2,
  output logic [31:0]        resp3,
  output logic               busy,
  output logic               sd_clk,
  output logic               cmd_out,
  output logic               cmd_oe,
  input  logic               cmd_in
);

  localparam int TX_BITS = 48;
  localparam int SH_BITS = 48;
  localparam int LG_BITS = 136;

  typedef enum logic [1:0] {S_IDLE, S_TX, S_WAIT, S_RX} st_t;

  function automatic logic [6:0] crc7_of(input logic [119:0] d, input int n);
    logic [6:0] c;
    logic fb;
    c = '0;
    for (int i = 0; i < 120; i++) begin
      if (i < n) begin
        fb = d[119-i] ^ c[6];
        c  = {c[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
      end
    end
    return c;
  endfunction

  st_t                 state;
  logic [PRESC_W-1:0]  div_cnt;
  logic [PRESC_W:0]    eff, hlf;
  logic                rise_ev, fall_ev;
  logic [47:0]         frame_q;
  logic [7:0]          bcnt;
  logic [TOUT_W-1:0]   tcnt;
  logic                want_rsp, long_q, skip_q;
  logic [134:0]        rx_sr;
  logic [135:0]        nxt;
  logic [7:0]          first_byte;
  logic [6:0]          tx_crc, rx_crc;
  logic [7:0]          rx_total;
  logic                start_req, done_tx, start_seen, tout_hit, rx_last, crc_bad;

  assign eff     = (presc == '0) ? (PRESC_W+1)'(1) : {1'b0, presc};
  assign hlf     = (eff + 1'b1) >> 1;
  assign rise_ev = {1'b0, div_cnt} >= eff;
  assign fall_ev = !rise_ev && ({1'b0, div_cnt} == hlf - 1'b1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      div_cnt <= '0;
      sd_clk  <= 1'b0;
    end else begin
      div_cnt <= rise_ev ? '0 : div_cnt + 1'b1;
      if (rise_ev)      sd_clk <= 1'b1;
      else if (fall_ev) sd_clk <= 1'b0;
    end

  assign first_byte = (ctl_word[7:0] | 8'h40) & 8'h7F;
  assign tx_crc     = crc7_of({first_byte, cmd_arg, 80'b0}, 40);
  assign start_req  = ctl_we && ctl_word[8] && state == S_IDLE;

  assign nxt        = {rx_sr, cmd_in};
  assign rx_total   = long_q ? 8'(LG_BITS) : 8'(SH_BITS);
  assign rx_crc     = long_q ? crc7_of(nxt[127:8], 120) : crc7_of({nxt[47:8], 80'b0}, 40);

  assign done_tx    = state == S_TX && fall_ev && bcnt == 8'(TX_BITS);
  assign start_seen = state == S_WAIT && rise_ev && !cmd_in;
  assign tout_hit   = state == S_WAIT && rise_ev && cmd_in && tcnt == TOUT_W'(TOUT_CYC-1);
  assign rx_last    = state == S_RX && rise_ev && (bcnt + 8'd1 == rx_total);
  assign crc_bad    = rx_last && (rx_crc != nxt[7:1]) && !skip_q;
  assign busy       = state != S_IDLE;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state    <= S_IDLE;
      frame_q  <= '0;
      bcnt     <= '0;
      tcnt     <= '0;
      want_rsp <= 1'b0;
      long_q   <= 1'b0;
      skip_q   <= 1'b0;
      rx_sr    <= '0;
      cmd_out  <= 1'b1;
      cmd_oe   <= 1'b0;
      resp0    <= '0;
      resp1    <= '0;
      resp2    <= '0;
      resp3    <= '0;
    end else begin
      case (state)
        S_IDLE:
          if (start_req) begin
            frame_q  <= {first_byte, cmd_arg, tx_crc, 1'b1};
            want_rsp <= ctl_word[9];
            long_q   <= ctl_word[10];
            skip_q   <= crc_skip;
            bcnt     <= '0;
            state    <= S_TX;
          end
        S_TX:
          if (fall_ev) begin
            if (done_tx) begin
              cmd_oe  <= 1'b0;
              cmd_out <= 1'b1;
              tcnt    <= '0;
              state   <= want_rsp ? S_WAIT : S_IDLE;
            end else begin
              cmd_oe  <= 1'b1;
              cmd_out <= frame_q[47];
              frame_q <= {frame_q[46:0], 1'b0};
              bcnt    <= bcnt + 8'd1;
            end
          end
        S_WAIT:
          if (start_seen) begin
            rx_sr <= '0;
            bcnt  <= 8'd1;
            state <= S_RX;
          end else if (tout_hit) begin
            state <= S_IDLE;
          end else if (rise_ev) begin
            tcnt <= tcnt + 1'b1;
          end
        S_RX:
          if (rise_ev) begin
            rx_sr <= nxt[134:0];
            bcnt  <= bcnt + 8'd1;
            if (rx_last) begin
              state <= S_IDLE;
              if (long_q) begin
                resp0 <= nxt[127:96];
                resp1 <= nxt[95:64];
                resp2 <= nxt[63:32];
                resp3 <= nxt[31:0];
              end else begin
                resp0 <= nxt[39:8];
              end
            end
          end
        default: state <= S_IDLE;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sts <= '0;
    else        sts <= (sts & ~(sts_we ? sts_wdata : 4'b0))
                     | {crc_bad, done_tx, tout_hit, rx_last};

  AST_START_BIT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_oe) |-> !cmd_out); // R1
  AST_END_BIT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cmd_oe) |-> $past(cmd_out)); // R2
  AST_DRIVE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_oe && !$stable(cmd_out)) |-> $fell(sd_clk)); // R4
  AST_SENT_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cmd_oe) |-> sts[11]); // R4
  AST_IDLE_NOT_DRIVING: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !cmd_oe); // R4
  AST_IGNORE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ctl_we) |=> ($stable(long_q) && $stable(want_rsp) && $stable(skip_q))); // R12
  AST_CLEAR_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sts[9]) |-> $past(sts_we && sts_wdata[9])); // R11

endmodule

// File: tb/sd_cmd_engine_bench.sv
`timescale 1ns/1ps
module sd_cmd_engine_bench;
  logic clk = 0, rst_n = 0;
  logic [7:0] presc = 8'd1;
  logic [31:0] cmd_arg = '0;
  logic ctl_we = 0, crc_skip = 0, sts_we = 0, cmd_in = 1;
  logic [10:0] ctl_word = '0;
  logic [12:9] sts_wdata = '0, sts;
  logic [31:0] resp0, resp1, resp2, resp3;
  logic busy, sd_clk, cmd_out, cmd_oe;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  sd_cmd_engine u_sd_cmd_engine (
    .clk(clk), .rst_n(rst_n), .presc(presc), .cmd_arg(cmd_arg), .ctl_we(ctl_we),
    .ctl_word(ctl_word), .crc_skip(crc_skip), .sts_we(sts_we), .sts_wdata(sts_wdata),
    .sts(sts), .resp0(resp0), .resp1(resp1), .resp2(resp2), .resp3(resp3),
    .busy(busy), .sd_clk(sd_clk), .cmd_out(cmd_out), .cmd_oe(cmd_oe), .cmd_in(cmd_in));

  function automatic logic [6:0] bcrc(input logic [119:0] d, input int n);
    logic [6:0] r = '0;
    for (int i = 0; i < n; i++)
      r = {r[5:0], 1'b0} ^ ((d[119-i] ^ r[6]) ? 7'b0001001 : 7'b0);
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [135:0] act, input logic [135:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_all();
    @(negedge clk); sts_we = 1; sts_wdata = 4'hF;
    @(negedge clk); sts_we = 0; sts_wdata = 0;
  endtask

  task automatic write_ctl(input logic [10:0] w, input logic [31:0] a, input bit sk);
    @(negedge clk); ctl_word = w; cmd_arg = a; crc_skip = sk; ctl_we = 1;
    @(negedge clk); ctl_we = 0;
  endtask

  task automatic collect(output logic [47:0] got);
    int n = 0;
    got = '0;
    while (n < 48) begin
      @(posedge sd_clk);
      if (cmd_oe) begin got = {got[46:0], cmd_out}; n++; end
    end
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  // kind: 0 none, 1 short, 2 long ; dly >= 64 means card stays silent
  task automatic run_cmd(input logic [5:0] idx, input logic [31:0] arg, input int kind,
                         input bit sk, input int dly, input bit bad,
                         input logic [119:0] body, input logic [31:0] pay);
    logic [47:0] got, expf;
    logic [135:0] rsp;
    logic [3:0] es;
    int nb;
    expf = {2'b01, idx, arg, bcrc({2'b01, idx, arg, 80'b0}, 40), 1'b1};
    if (kind == 2) begin
      rsp = {8'b0011_1111, body, bcrc(body, 120), 1'b1}; nb = 136;
    end else begin
      rsp = {88'b0, 2'b00, idx, pay, bcrc({2'b00, idx, pay, 80'b0}, 40), 1'b1}; nb = 48;
    end
    if (bad) rsp[1] = ~rsp[1];
    clear_all();
    write_ctl({kind == 2, kind != 0, 1'b1, 2'b11, idx}, arg, sk);
    collect(got);
    chk(got[47:8] == expf[47:8], "R1 first byte and argument", 136'(got), 136'(expf));
    chk(got[7:0] == expf[7:0], "R2 crc and end bit", 136'(got[7:0]), 136'(expf[7:0]));
    if (kind != 0 && dly < 64) begin
      repeat (dly) @(posedge sd_clk);
      for (int i = nb - 1; i >= 0; i--) begin
        @(negedge sd_clk); #1 cmd_in = rsp[i];
      end
      @(negedge sd_clk); #1 cmd_in = 1;
    end
    wait_idle();
    es = 4'b0100;
    if (kind != 0) begin
      if (dly >= 64) es |= 4'b0010;
      else begin
        es |= 4'b0001;
        if (bad && !sk) es |= 4'b1000;
      end
    end
    chk(sts == es, kind == 0 ? "R5 no-response flags" : dly >= 64 ? "R8 timeout flags" :
        bad ? (sk ? "R10 crc suppressed" : "R9 crc error flag") : "R4 R6 sent and response flags",
        136'(sts), 136'(es));
    if (kind == 1 && dly < 64)
      chk(resp0 == pay, "R6 short payload", 136'(resp0), 136'(pay));
    if (kind == 2 && dly < 64)
      chk({resp0, resp1, resp2, resp3} == rsp[127:0], "R7 long payload",
          136'({resp0, resp1, resp2, resp3}), 136'(rsp[127:0]));
  endtask

  task automatic chk_clk(input logic [7:0] p);
    realtime t0, t1, t2;
    int e;
    @(negedge clk); presc = p;
    repeat (3) @(posedge sd_clk);
    t0 = $realtime; @(negedge sd_clk); t1 = $realtime; @(posedge sd_clk); t2 = $realtime;
    e = (p == 0) ? 1 : p;
    chk(int'((t2 - t0) / 5.0) == e + 1, "R3 period", 136'(int'((t2 - t0) / 5.0)), 136'(e + 1));
    chk(int'((t1 - t0) / 5.0) == (e + 1) / 2, "R3 high phase", 136'(int'((t1 - t0) / 5.0)), 136'((e + 1) / 2));
  endtask

  initial begin
    #1000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [47:0] g;
    logic [119:0] b;
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    chk(!busy && !cmd_oe && cmd_out && sts == 0, "R13 reset state",
        136'({busy, cmd_oe, cmd_out, sts}), 136'(7'b0010000));
    rst_n = 1;
    repeat (3) @(negedge clk);

    chk_clk(8'd0); chk_clk(8'd1); chk_clk(8'd2); chk_clk(8'd5);

    presc = 8'd1;
    run_cmd(6'd0, 32'h0, 0, 0, 0, 0, '0, 0);
    run_cmd(6'd13, 32'hA5A5_0001, 1, 0, 0, 0, '0, 32'h0000_0900);
    run_cmd(6'd2, 32'h0, 2, 0, 5, 0, {4{30'h2AB5_1C3D}}, 0);
    run_cmd(6'd17, 32'h1234_5678, 1, 0, 63, 0, '0, 32'hDEAD_BEEF);
    run_cmd(6'd17, 32'h1234_5678, 1, 0, 64, 0, '0, 0);
    run_cmd(6'd41, 32'h00FF_8000, 1, 0, 2, 1, '0, 32'h80FF_8000);
    run_cmd(6'd41, 32'h00FF_8000, 1, 1, 2, 1, '0, 32'h80FF_8000);
    run_cmd(6'd9, 32'h0001_0000, 2, 0, 1, 1, {4{30'h1555_0F0F}}, 0);

    // R12: start request while busy and a write without start are ignored
    clear_all();
    write_ctl({3'b001, 2'b00, 6'd7}, 32'h0007_0000, 0);
    write_ctl({3'b111, 2'b00, 6'd55}, 32'hFFFF_FFFF, 1);
    collect(g);
    chk(g[47:8] == {2'b01, 6'd7, 32'h0007_0000}, "R12 busy start ignored",
        136'(g[47:8]), 136'({2'b01, 6'd7, 32'h0007_0000}));
    wait_idle();
    write_ctl({3'b000, 2'b00, 6'd3}, 32'h1, 0);
    repeat (20) @(negedge clk);
    chk(!busy && !cmd_oe && sts == 4'b0100, "R12 no-start write ignored",
        136'({busy, cmd_oe, sts}), 136'(6'b000100));

    // R11: clear write in the cycle the sent flag is set; set must win
    clear_all();
    presc = 8'd3;
    run_cmd(6'd13, 32'h0, 1, 0, 0, 0, '0, 32'h1);
    write_ctl({3'b001, 2'b00, 6'd12}, 32'h0, 0);
    collect(g);
    repeat (1) @(posedge clk);
    @(negedge clk); sts_we = 1; sts_wdata = 4'hF;
    @(negedge clk); sts_we = 0; sts_wdata = 0;
    chk(sts == 4'b0100, "R11 set wins over clear", 136'(sts), 136'(4'b0100));
    wait_idle();
    clear_all();
    chk(sts == 4'b0000, "R11 write one clears", 136'(sts), 136'(0));

    for (int it = 0; it < 30; it++) begin
      int k, d;
      presc = 8'($urandom_range(1, 3));
      k = $urandom_range(0, 2);
      d = ($urandom_range(0, 9) == 0) ? 64 : $urandom_range(0, 40);
      b = {$urandom, $urandom, $urandom, $urandom};
      run_cmd(6'($urandom), $urandom, k, $urandom_range(0, 1), d,
              $urandom_range(0, 2) == 0, b, $urandom);
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule